// File: doc/BRIEF.md
# Floating-Point Exception Status Controller

This block holds the floating-point status and control word that sits beside an arithmetic unit. Whenever the unit reports that an operation has finished, the block records which of five exception kinds the operation raised. These are invalid, divide-by-zero, overflow, underflow and inexact. The per-operation cause bits are rebuilt from scratch. The same bits are also merged into a set of sticky flags that only ever accumulate. A trap is requested whenever a fresh cause coincides with an enabled exception. Software can overwrite the whole word through a write port. That write is masked to the defined fields and never produces a trap.

The block also decodes two controls for the arithmetic unit from the word. The first is a truncation select, taken from the two-bit rounding-mode field. The second is a flush-to-zero select, taken from the denormal-control bit. An operation that only approximates its result, such as a reciprocal square root estimate, asserts the forced-inexact input. This marks the result inexact unless a stronger exception was already reported.

The trap path is a two-state machine. State ST_IDLE holds the trap output low. The transition ST_IDLE to ST_TRAP is taken on an accepted operation whose cause bits meet a set enable bit. ST_TRAP drives a one-cycle trap request carrying the code 0x120. From ST_TRAP, the transition ST_TRAP to ST_TRAP is taken when another trapping operation arrives in the next cycle. The transition ST_TRAP to ST_IDLE is taken on anything else. A software write always returns the machine to ST_IDLE.

Top module: `fpsc_top`

## Requirements
- R1: After reset the word reads 0, the trap request is low, the truncation select is 0 (round to nearest even) and flush-to-zero is 0.
- R2: On an accepted operation, the whole cause field (bits 16:12) is replaced by the new causes in the cycle after the operation strobe. The raw input bit order is bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid, and the cause field uses the same order.
- R3: On an accepted operation, the new causes are ORed into the flag field (bits 6:2, same order). An operation never clears a flag.
- R4: If an accepted operation yields a cause bit whose enable bit (field 11:7, same order) is set, the trap request is high for one cycle in the cycle after the strobe, with trap code 0x120. Otherwise the trap request and the code are 0.
- R5: A software write stores the write data masked to bits 16:0 and bit 18; every other bit reads 0. The new value is visible in the cycle after the write.
- R6: The truncation select is 1 exactly when the rounding field (bits 1:0) holds 2'b01. Any other value selects round to nearest even (output 0).
- R7: The flush-to-zero output equals bit 18 of the word.
- R8: With forced-inexact asserted and no raw exception, the cause becomes inexact alone. If any raw exception is present, the causes equal the raw bits and nothing is forced.
- R9: A software write never raises a trap, even when the written causes and enables overlap. When a write and an operation strobe arrive in the same cycle, the write wins and the operation is discarded.
- R10: Trapping operations on consecutive cycles give a trap request on consecutive cycles. A non-trapping operation or an idle cycle drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_done | input | 1 | Operation completion strobe from the arithmetic unit |
| exc_raw | input | 5 | Raw exceptions of the finished operation (bit0 I, 1 U, 2 O, 3 Z, 4 V) |
| force_inexact | input | 1 | Operation is an approximation; mark inexact if nothing else was raised |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| csr_q | output | 32 | Current status and control word |
| rnd_toward_zero | output | 1 | 1: truncate, 0: round to nearest even |
| flush_zero | output | 1 | Flush-to-zero control |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code while trap_req is high, otherwise 0 |

## Verification
Operations are run with a single raw exception after a different earlier one. This tells apart a cause field that is rebuilt from one that only accumulates, while the flags must keep both. The forced-inexact input is tried with no raw exception and again with invalid raised, which separates forcing from priority. The trap is tried with a matching enable, with a non-matching enable, back to back and against a simultaneous software write, which separates cause-and-enable gating from plain cause detection. Writes of all ones and of single rounding codes check the mask and the two control decodes.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    localparam int CSR_W     = 32;
    localparam int N_EXC     = 5;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = 2;
    localparam int EN_LSB    = FLAG_LSB + N_EXC;
    localparam int CAUSE_LSB = EN_LSB + N_EXC;
    localparam int DN_BIT    = CAUSE_LSB + N_EXC + 1;

    localparam logic [RM_W-1:0] RM_ZERO = 2'b01;

    // bit order inside each five-bit field: i at bit 0 ... v at bit 4
    typedef struct packed {
        logic v;
        logic z;
        logic o;
        logic u;
        logic i;
    } exc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_TRAP = 2'b01
    } trap_st_t;

    function automatic logic [CSR_W-1:0] defined_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int k = 0; k < CAUSE_LSB + N_EXC; k++) begin
            m[k] = 1'b1;
        end
        m[DN_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [CSR_W-1:0] CSR_MASK = defined_mask();

endpackage

// File: rtl/fpsc_cause_gen.sv
module fpsc_cause_gen
    import fpsc_pkg::*;
(
    input  logic [N_EXC-1:0] exc_raw,
    input  logic             force_inexact,
    output exc_t             cause_new
);

    always_comb begin
        cause_new = exc_t'(exc_raw);
        if (force_inexact && (exc_raw == '0)) begin
            cause_new.i = 1'b1;
        end
    end

endmodule

// File: rtl/fpsc_csr_reg.sv
module fpsc_csr_reg
    import fpsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [CSR_W-1:0] sw_wdata,
    input  logic             op_en,
    input  exc_t             cause_new,
    output logic [CSR_W-1:0] csr_q
);

    logic [CSR_W-1:0] csr_after_op;
    logic [N_EXC-1:0] cause_vec;

    assign cause_vec = cause_new;

    always_comb begin
        csr_after_op = csr_q;
        for (int k = 0; k < N_EXC; k++) begin
            csr_after_op[CAUSE_LSB + k] = cause_vec[k];
            csr_after_op[FLAG_LSB + k]  = csr_q[FLAG_LSB + k] | cause_vec[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (sw_we) begin
            csr_q <= sw_wdata & CSR_MASK;
        end else if (op_en) begin
            csr_q <= csr_after_op;
        end
    end

endmodule

// File: rtl/fpsc_trap_fsm.sv
module fpsc_trap_fsm
    import fpsc_pkg::*;
#(
    parameter int                 CODE_W    = 12,
    parameter logic [CODE_W-1:0]  TRAP_CODE = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  exc_t              cause_new,
    input  logic [N_EXC-1:0]  enables,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);

    trap_st_t state_q;
    trap_st_t state_d;
    logic     hit;

    assign hit = op_en && ((N_EXC'(cause_new) & enables) != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = hit ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_d = hit ? ST_TRAP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        trap_req  = 1'b0;
        trap_code = '0;
        unique case (state_q)
            ST_IDLE: begin
                trap_req  = 1'b0;
                trap_code = '0;
            end
            ST_TRAP: begin
                trap_req  = 1'b1;
                trap_code = TRAP_CODE;
            end
            default: begin
                trap_req  = 1'b0;
                trap_code = '0;
            end
        endcase
    end

endmodule

// File: rtl/fpsc_top.sv
module fpsc_top
    import fpsc_pkg::*;
#(
    parameter int                 CODE_W    = 12,
    parameter logic [CODE_W-1:0]  TRAP_CODE = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [4:0]        exc_raw,
    input  logic              force_inexact,
    input  logic              sw_we,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       csr_q,
    output logic              rnd_toward_zero,
    output logic              flush_zero,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);

    exc_t cause_new;
    logic op_en;

    // a software write in the same cycle discards the operation
    assign op_en = op_done && !sw_we;

    fpsc_cause_gen u_cause (
        .exc_raw       (exc_raw),
        .force_inexact (force_inexact),
        .cause_new     (cause_new)
    );

    fpsc_csr_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (sw_we),
        .sw_wdata  (sw_wdata),
        .op_en     (op_en),
        .cause_new (cause_new),
        .csr_q     (csr_q)
    );

    fpsc_trap_fsm #(
        .CODE_W    (CODE_W),
        .TRAP_CODE (TRAP_CODE)
    ) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_en     (op_en),
        .cause_new (cause_new),
        .enables   (csr_q[EN_LSB +: N_EXC]),
        .trap_req  (trap_req),
        .trap_code (trap_code)
    );

    assign rnd_toward_zero = (csr_q[RM_LSB +: RM_W] == RM_ZERO);
    assign flush_zero      = csr_q[DN_BIT];

endmodule

// File: rtl/fpsc_checker.sv
module fpsc_checker
    import fpsc_pkg::*;
#(
    parameter int                CODE_W    = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_done,
    input logic [4:0]        exc_raw,
    input logic              force_inexact,
    input logic              sw_we,
    input logic [31:0]       csr_q,
    input logic              trap_req,
    input logic [CODE_W-1:0] trap_code
);

    p_cause_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we && !force_inexact)
        |=> (csr_q[CAUSE_LSB +: N_EXC] == $past(exc_raw)));

    p_flags_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we
        |=> ((csr_q[FLAG_LSB +: N_EXC] & $past(csr_q[FLAG_LSB +: N_EXC]))
             == $past(csr_q[FLAG_LSB +: N_EXC])));

    p_trap_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (((csr_q[CAUSE_LSB +: N_EXC] & csr_q[EN_LSB +: N_EXC]) != '0)
                      && (trap_code == TRAP_CODE)));

    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_q & ~CSR_MASK) == '0));

    p_force_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we && force_inexact && (exc_raw == '0))
        |=> (csr_q[CAUSE_LSB +: N_EXC] == 5'b00001));

    p_no_trap_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> !trap_req);

endmodule

bind fpsc_top fpsc_checker #(
    .CODE_W    (CODE_W),
    .TRAP_CODE (TRAP_CODE)
) u_fpsc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_done       (op_done),
    .exc_raw       (exc_raw),
    .force_inexact (force_inexact),
    .sw_we         (sw_we),
    .csr_q         (csr_q),
    .trap_req      (trap_req),
    .trap_code     (trap_code)
);

// File: tb/fpsc_top_tb_top.sv
`timescale 1ns/1ps
module fpsc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_done = 1'b0;
    logic [4:0]  exc_raw = '0;
    logic        force_inexact = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] csr_q;
    logic        rnd_toward_zero;
    logic        flush_zero;
    logic        trap_req;
    logic [11:0] trap_code;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpsc_top dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_done         (op_done),
        .exc_raw         (exc_raw),
        .force_inexact   (force_inexact),
        .sw_we           (sw_we),
        .sw_wdata        (sw_wdata),
        .csr_q           (csr_q),
        .rnd_toward_zero (rnd_toward_zero),
        .flush_zero      (flush_zero),
        .trap_req        (trap_req),
        .trap_code       (trap_code)
    );

    // behavioural reference model
    logic [31:0] m_csr;
    logic        m_trap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_csr  <= 32'h0;
            m_trap <= 1'b0;
        end else if (sw_we) begin
            m_csr  <= sw_wdata & 32'h0005_FFFF;
            m_trap <= 1'b0;
        end else if (op_done) begin
            logic [4:0] c;
            logic [4:0] fl;
            logic [4:0] en;
            c  = (force_inexact && exc_raw == 5'd0) ? 5'b00001 : exc_raw;
            fl = m_csr[6:2] | c;
            en = m_csr[11:7];
            m_csr  <= {m_csr[31:17], c, en, fl, m_csr[1:0]};
            m_trap <= ((c & en) != 5'd0);
        end else begin
            m_trap <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check("R2 cause field", {27'd0, csr_q[16:12]}, {27'd0, m_csr[16:12]});
            check("R3 flag field", {27'd0, csr_q[6:2]}, {27'd0, m_csr[6:2]});
            check("R5 whole word", csr_q, m_csr);
            check("R4 trap_req", {31'd0, trap_req}, {31'd0, m_trap});
            check("R4 trap_code", {20'd0, trap_code}, m_trap ? 32'h120 : 32'h0);
            check("R6 rounding", {31'd0, rnd_toward_zero}, {31'd0, m_csr[1:0] == 2'b01});
            check("R7 flush", {31'd0, flush_zero}, {31'd0, m_csr[18]});
        end
    end

    task automatic do_write(input logic [31:0] v);
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0; sw_wdata = '0;
        #1;
    endtask

    task automatic do_op(input logic [4:0] raw, input logic frc);
        @(negedge clk);
        op_done = 1'b1; exc_raw = raw; force_inexact = frc;
        @(negedge clk);
        op_done = 1'b0; exc_raw = '0; force_inexact = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset word", csr_q, 32'h0);
        check("R1 reset trap", {31'd0, trap_req}, 32'h0);
        check("R1 reset rounding", {31'd0, rnd_toward_zero}, 32'h0);
        check("R1 reset flush", {31'd0, flush_zero}, 32'h0);
        rst_n = 1'b1;

        // mask, no trap on overlapping write
        do_write(32'hFFFF_FFFF);
        check("R5 masked write", csr_q, 32'h0005_FFFF);
        check("R9 write no trap", {31'd0, trap_req}, 32'h0);
        check("R6 rm=11 nearest", {31'd0, rnd_toward_zero}, 32'h0);
        check("R7 flush set", {31'd0, flush_zero}, 32'h1);
        @(negedge clk); #1;
        check("R9 still no trap", {31'd0, trap_req}, 32'h0);

        do_write(32'h0000_0001);
        check("R6 rm=01 truncate", {31'd0, rnd_toward_zero}, 32'h1);
        check("R7 flush clear", {31'd0, flush_zero}, 32'h0);

        // cause rebuild and sticky flags
        do_write(32'h0);
        do_op(5'b00100, 1'b0);
        check("R2 overflow cause", csr_q, 32'h0000_4010);
        do_op(5'b00001, 1'b0);
        check("R2 R3 cause replaced flags kept", csr_q, 32'h0000_1014);

        // forced inexact
        do_op(5'b00000, 1'b1);
        check("R8 forced inexact", csr_q, 32'h0000_1014);
        do_op(5'b10000, 1'b1);
        check("R8 invalid wins", csr_q, 32'h0001_0054);
        do_op(5'b00000, 1'b0);
        check("R3 flags survive clean op", csr_q, 32'h0000_0054);

        // trap with matching enable (divide-by-zero)
        do_write(32'h0000_0400);
        do_op(5'b01000, 1'b0);
        check("R4 trap raised", {31'd0, trap_req}, 32'h1);
        check("R4 trap code", {20'd0, trap_code}, 32'h120);
        check("R4 word", csr_q, 32'h0000_8420);
        @(negedge clk); #1;
        check("R10 pulse ends", {31'd0, trap_req}, 32'h0);

        // non-matching enable
        do_op(5'b00100, 1'b0);
        check("R4 no trap unmatched", {31'd0, trap_req}, 32'h0);

        // back to back trapping ops
        @(negedge clk);
        op_done = 1'b1; exc_raw = 5'b01000;
        @(negedge clk); #1;
        check("R10 first pulse", {31'd0, trap_req}, 32'h1);
        @(negedge clk);
        exc_raw = 5'b00001;
        #1;
        check("R10 second pulse", {31'd0, trap_req}, 32'h1);
        @(negedge clk);
        op_done = 1'b0; exc_raw = '0;
        #1;
        check("R10 dropped on non-trapping op", {31'd0, trap_req}, 32'h0);

        // write and operation together: write wins
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = 32'h0000_0402;
        op_done = 1'b1; exc_raw = 5'b01000;
        @(negedge clk);
        sw_we = 1'b0; sw_wdata = '0; op_done = 1'b0; exc_raw = '0;
        #1;
        check("R9 write beats op", csr_q, 32'h0000_0402);
        check("R9 collision no trap", {31'd0, trap_req}, 32'h0);
        check("R6 rm=10 nearest", {31'd0, rnd_toward_zero}, 32'h0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule